// File: doc/BRIEF.md
# Prioritized External Interrupt Request Controller

This block collects interrupt requests from four external pins and presents at most one of them to the processor. Each pin has its own 16-bit control register. The register sets how the pin is sensed (a latched rising edge or a live high level), whether the pin is masked, and a 3-bit priority. A smaller priority value is more urgent, and 7 is the least urgent. When the processor acknowledges, the winning request is cleared and that input is marked in service. The input stays in service until software writes its number to the end-of-interrupt address. While an input is in service, requests of equal or lower urgency are held back.

Inputs 0 and 1 have two extra options. The first is a nested mode that lets the same input interrupt itself again while it is in service. The second is a cascade option. It turns pin 2 (for input 0) or pin 3 (for input 1) into an output that carries an acknowledge strobe for an external secondary controller. The processor side sees a request line, an 8-bit type code and a one-cycle acknowledge input. Software reaches the control registers through a simple write strobe, an address and a combinational read-data bus.

Top module: `eirq_ctrl`

## Requirements
- R1: After reset every control register reads 000Fh (masked, edge sensing, priority 7). After reset `irq_o`, `cas_ack_o` and `cas_ack_en_o` are low.
- R2: Addresses 0 to 3 select the control registers of inputs 0 to 3. In each register, bits 2:0 hold the priority, bit 3 is the mask and bit 4 selects level sensing. Bit 5 (cascade) and bit 6 (nested) exist only for inputs 0 and 1. All other bits read 0.
- R3: With bit 4 clear, a rising edge on a pin latches a request. `irq_o` rises after the third rising clock edge that follows the pin going high. The request stays pending after the pin falls, until it is acknowledged.
- R4: With bit 4 set, the request follows the pin level, delayed by two clock edges. If the pin falls before acknowledge, the request is gone and nothing is latched.
- R5: A mask bit of 1 keeps the input from raising `irq_o`. An edge that arrives while the input is masked is still latched and is presented once the mask bit is cleared.
- R6: Among eligible requests, the smallest priority value wins. On equal values the lower-numbered input wins. `irq_type_o` is 0Ch plus the winning input number.
- R7: A one-cycle `inta_i` pulse while `irq_o` is high clears the winner's latched request and sets its in-service flag.
- R8: While any input is in service, requests whose priority value is equal to or larger than that input's value are blocked. A request with a strictly smaller value is not blocked. Writing input number n (bits 1:0) to address 4 clears the in-service flag of input n.
- R9: When bit 6 is set for input 0 or 1, that input's own in-service flag does not block its new requests.
- R10: When bit 5 is set for input k (k = 0 or 1), `cas_ack_en_o[k]` is high and pin k+2 is ignored as a request source. An acknowledge of input k then drives `cas_ack_o[k]` high for exactly the one cycle after the acknowledge edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_irq_i | input | 4 | External interrupt pins, asynchronous to `clk` |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address: 0 to 3 select the control registers, 4 is the end-of-interrupt address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` (combinational) |
| inta_i | input | 1 | One-cycle interrupt acknowledge from the processor |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_type_o | output | 8 | Type code of the current winner |
| cas_ack_o | output | 2 | Cascade acknowledge strobes for inputs 0 and 1 |
| cas_ack_en_o | output | 2 | Output enables for pins 2 and 3 when they act as strobes |

## Verification
The first pattern is a single-cycle pulse on a pin in edge mode. The second is a level that is held and then dropped before acknowledge. Together they separate latched capture from live capture. Pulses that reach three inputs on the same edge, two of them with equal priority, show whether the design orders requests by value and breaks ties by index. Acknowledges issued with nesting on and off, and a more urgent input arriving while another is in service, show the blocking rule and its self-re-entry exception. A cascade sequence checks that pin 3 is ignored while input 1 owns it, that the pin's held edge is released once the cascade bit is cleared, and that the strobe appears only in the cycle after the acknowledge.

// File: rtl/eirq_pkg.sv
// Package: field positions, reset value and write masks shared by the
// interrupt controller modules.
package eirq_pkg;
    localparam int CTL_W     = 16;
    localparam int PRIO_W    = 3;
    localparam int BIT_MASK  = 3;
    localparam int BIT_LVL   = 4;
    localparam int BIT_CAS   = 5;
    localparam int BIT_SFNM  = 6;
    localparam logic [CTL_W-1:0] CTL_RESET   = 16'h000F;
    localparam logic [CTL_W-1:0] WMASK_CAS   = 16'h007F;
    localparam logic [CTL_W-1:0] WMASK_PLAIN = 16'h001F;

    // Writable-bit mask for a channel: cascade-capable channels keep two more bits.
    function automatic logic [CTL_W-1:0] wr_mask(input bit cas_capable);
        return cas_capable ? WMASK_CAS : WMASK_PLAIN;
    endfunction
endpackage

// File: rtl/eirq_in_chan.sv
// Module: eirq_in_chan
// Synchronizes one asynchronous interrupt pin with two flops, detects rising
// edges and keeps an edge request pending until cleared. In level mode the
// request is the synchronized level and no edge is held.
// Assumes clr_i is a single-cycle pulse from the acknowledge logic.
module eirq_in_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic level_mode_i,
    input  logic clr_i,
    output logic req_o
);
    logic sync1_q;
    logic sync2_q;
    logic prev_q;
    logic pend_q;
    logic rise;

    assign rise = sync2_q & ~prev_q;

    // Two-flop synchronizer plus a delay flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= pin_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    // Edge request flag: a new edge wins over a clear; level mode empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!level_mode_i && rise) begin
            pend_q <= 1'b1;
        end else if (level_mode_i || clr_i) begin
            pend_q <= 1'b0;
        end
    end

    // Selected request source.
    always_comb begin
        req_o = level_mode_i ? sync2_q : pend_q;
    end
endmodule

// File: rtl/eirq_cfg_regs.sv
// Module: eirq_cfg_regs
// Holds one control register per channel. Reserved bits are forced to zero.
// Provides a combinational read mux and decodes end-of-interrupt writes.
// Assumes channels below NUM_CAS have the cascade and nested bits.
module eirq_cfg_regs
    import eirq_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int NUM_CAS = 2,
    parameter int ADDR_W  = 3,
    parameter int IDX_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [CTL_W-1:0]         wdata_i,
    output logic [CTL_W-1:0]         rdata_o,
    output logic [NUM_CH-1:0][PRIO_W-1:0] prio_o,
    output logic [NUM_CH-1:0]        mask_o,
    output logic [NUM_CH-1:0]        level_o,
    output logic [NUM_CAS-1:0]       casc_o,
    output logic [NUM_CAS-1:0]       sfnm_o,
    output logic                     eoi_o,
    output logic [IDX_W-1:0]         eoi_idx_o
);
    localparam logic [ADDR_W-1:0] EOI_ADDR = ADDR_W'(NUM_CH);

    logic [NUM_CH-1:0][CTL_W-1:0] ctl_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ctl
        localparam logic [CTL_W-1:0] WM = wr_mask(g < NUM_CAS);

        // Control register of channel g with reserved bits held at zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_q[g] <= CTL_RESET;
            end else if (we_i && addr_i == ADDR_W'(g)) begin
                ctl_q[g] <= wdata_i & WM;
            end
        end

        assign prio_o[g]  = ctl_q[g][PRIO_W-1:0];
        assign mask_o[g]  = ctl_q[g][BIT_MASK];
        assign level_o[g] = ctl_q[g][BIT_LVL];

        if (g < NUM_CAS) begin : g_cas
            assign casc_o[g] = ctl_q[g][BIT_CAS];
            assign sfnm_o[g] = ctl_q[g][BIT_SFNM];
        end
    end

    // Read mux: unmapped addresses return zero.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr_i == ADDR_W'(i)) begin
                rdata_o = ctl_q[i];
            end
        end
    end

    // End-of-interrupt decode: the input number is in the low data bits.
    always_comb begin
        eoi_o     = we_i && (addr_i == EOI_ADDR);
        eoi_idx_o = wdata_i[IDX_W-1:0];
    end
endmodule

// File: rtl/eirq_arbiter.sv
// Module: eirq_arbiter
// Filters requests by mask, cascade ownership and in-service blocking, then
// picks the smallest priority value, breaking ties toward the lower index.
// Purely combinational; assumes in-service flags come from registered state.
module eirq_arbiter #(
    parameter int NUM_CH = 4,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_CH-1:0]             req_i,
    input  logic [NUM_CH-1:0]             mask_i,
    input  logic [NUM_CH-1:0]             suppress_i,
    input  logic [NUM_CH-1:0]             reenter_i,
    input  logic [NUM_CH-1:0]             isr_i,
    input  logic [NUM_CH-1:0][PRIO_W-1:0] prio_i,
    output logic                          any_o,
    output logic [IDX_W-1:0]              win_o
);
    logic [NUM_CH-1:0] blocked;
    logic [NUM_CH-1:0] elig;
    logic [PRIO_W-1:0] best;

    // In-service blocking: an equal or more urgent service holds a request back.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < NUM_CH; j++) begin
                if (isr_i[j] && (prio_i[j] <= prio_i[i]) && !(j == i && reenter_i[i])) begin
                    blocked[i] = 1'b1;
                end
            end
        end
    end

    // Eligible requests after masking, cascade ownership and blocking.
    always_comb begin
        elig = req_i & ~mask_i & ~suppress_i & ~blocked;
    end

    // Winner search: a strict compare keeps the lower index on ties.
    always_comb begin
        any_o = 1'b0;
        win_o = '0;
        best  = '1;
        for (int i = 0; i < NUM_CH; i++) begin
            if (elig[i] && (!any_o || prio_i[i] < best)) begin
                any_o = 1'b1;
                win_o = IDX_W'(i);
                best  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/eirq_ctrl.sv
// Module: eirq_ctrl (top)
// External interrupt controller: per-channel capture, configuration
// registers, priority arbitration, in-service tracking and cascade
// acknowledge strobes. Assumes inta_i is a one-cycle pulse and that the
// upper half of the channels serve as strobe pins for the lower half.
module eirq_ctrl
    import eirq_pkg::*;
#(
    parameter int          NUM_CH    = 4,
    parameter int          ADDR_W    = 3,
    parameter logic [7:0]  TYPE_BASE = 8'h0C,
    localparam int         NUM_CAS   = NUM_CH / 2,
    localparam int         IDX_W     = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CH-1:0]  ext_irq_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [CTL_W-1:0]   reg_wdata_i,
    output logic [CTL_W-1:0]   reg_rdata_o,
    input  logic               inta_i,
    output logic               irq_o,
    output logic [7:0]         irq_type_o,
    output logic [NUM_CAS-1:0] cas_ack_o,
    output logic [NUM_CAS-1:0] cas_ack_en_o
);
    logic [NUM_CH-1:0][PRIO_W-1:0] prio;
    logic [NUM_CH-1:0]  mask;
    logic [NUM_CH-1:0]  level;
    logic [NUM_CAS-1:0] casc;
    logic [NUM_CAS-1:0] sfnm;
    logic               eoi;
    logic [IDX_W-1:0]   eoi_idx;
    logic [NUM_CH-1:0]  req;
    logic [NUM_CH-1:0]  clr;
    logic [NUM_CH-1:0]  suppress;
    logic [NUM_CH-1:0]  reenter;
    logic [NUM_CH-1:0]  isr_q;
    logic [NUM_CAS-1:0] cas_q;
    logic               any;
    logic [IDX_W-1:0]   win;
    logic               take;

    eirq_cfg_regs #(
        .NUM_CH (NUM_CH),
        .NUM_CAS(NUM_CAS),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (reg_we_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .rdata_o  (reg_rdata_o),
        .prio_o   (prio),
        .mask_o   (mask),
        .level_o  (level),
        .casc_o   (casc),
        .sfnm_o   (sfnm),
        .eoi_o    (eoi),
        .eoi_idx_o(eoi_idx)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        eirq_in_chan u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .pin_i       (ext_irq_i[g]),
            .level_mode_i(level[g]),
            .clr_i       (clr[g]),
            .req_o       (req[g])
        );

        // Acknowledge decode for channel g.
        assign clr[g] = take && (win == IDX_W'(g));

        if (g < NUM_CAS) begin : g_lo
            assign suppress[g] = 1'b0;
            assign reenter[g]  = sfnm[g];
        end else begin : g_hi
            assign suppress[g] = casc[g-NUM_CAS];
            assign reenter[g]  = 1'b0;
        end
    end

    eirq_arbiter #(
        .NUM_CH(NUM_CH),
        .PRIO_W(PRIO_W),
        .IDX_W (IDX_W)
    ) u_arb (
        .req_i     (req),
        .mask_i    (mask),
        .suppress_i(suppress),
        .reenter_i (reenter),
        .isr_i     (isr_q),
        .prio_i    (prio),
        .any_o     (any),
        .win_o     (win)
    );

    // An acknowledge counts only when a request is being presented.
    always_comb begin
        take = inta_i && any;
    end

    // In-service flags: an acknowledge sets one, an end-of-interrupt clears one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (clr[i]) begin
                    isr_q[i] <= 1'b1;
                end else if (eoi && eoi_idx == IDX_W'(i)) begin
                    isr_q[i] <= 1'b0;
                end
            end
        end
    end

    // Cascade strobes: one cycle after an acknowledge of a cascaded channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cas_q <= '0;
        end else begin
            cas_q <= clr[NUM_CAS-1:0] & casc;
        end
    end

    // Processor-facing outputs.
    always_comb begin
        irq_o        = any;
        irq_type_o   = TYPE_BASE + 8'(win);
        cas_ack_o    = cas_q;
        cas_ack_en_o = casc;
    end
endmodule

// File: rtl/eirq_ctrl_chk.sv
// Module: eirq_ctrl_chk
// Property checker for eirq_ctrl, attached with bind. Observes ports only.
module eirq_ctrl_chk #(
    parameter int         NUM_CH    = 4,
    parameter int         NUM_CAS   = 2,
    parameter logic [7:0] TYPE_BASE = 8'h0C
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_o,
    input logic [7:0]         irq_type_o,
    input logic               inta_i,
    input logic [NUM_CAS-1:0] cas_ack_o,
    input logic [15:0]        reg_rdata_o
);
    AST_TYPE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((irq_type_o - TYPE_BASE) < 8'(NUM_CH))); // R6

    AST_CAS_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|cas_ack_o) |-> ($past(inta_i) && $past(irq_o))); // R10

    AST_CAS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cas_ack_o)); // R10

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[15:7] == 9'd0); // R2

    for (genvar k = 0; k < NUM_CAS; k++) begin : g_pulse
        AST_CAS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            cas_ack_o[k] |=> !cas_ack_o[k]); // R10
    end
endmodule

bind eirq_ctrl eirq_ctrl_chk #(
    .NUM_CH   (NUM_CH),
    .NUM_CAS  (NUM_CAS),
    .TYPE_BASE(TYPE_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_o      (irq_o),
    .irq_type_o (irq_type_o),
    .inta_i     (inta_i),
    .cas_ack_o  (cas_ack_o),
    .reg_rdata_o(reg_rdata_o)
);

// File: tb/eirq_ctrl_bench.sv
// Bench for eirq_ctrl: a behavioural reference model compared on every clock,
// plus directed checks at the points each requirement calls out.
module eirq_ctrl_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ext = '0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        inta = 1'b0;
    logic [15:0] rdata;
    logic        irq;
    logic [7:0]  itype;
    logic [1:0]  cas;
    logic [1:0]  cas_en;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit started = 0;

    eirq_ctrl u_eirq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_irq_i(ext),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .inta_i(inta), .irq_o(irq), .irq_type_o(itype),
        .cas_ack_o(cas), .cas_ack_en_o(cas_en)
    );

    always #(CLK_P/2) clk = ~clk;

    // Reference model state
    bit        m_s1 [4];
    bit        m_s2 [4];
    bit        m_pv [4];
    bit        m_pd [4];
    bit        m_is [4];
    bit        m_cas [2];
    bit [15:0] m_ctl [4];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_elig(input int i);
        int pi;
        bit r;
        pi = int'(m_ctl[i][2:0]);
        r = m_ctl[i][4] ? m_s2[i] : m_pd[i];
        if (!r || m_ctl[i][3]) return 0;
        if (i >= 2 && m_ctl[i-2][5]) return 0;
        for (int j = 0; j < 4; j++) begin
            if (m_is[j] && int'(m_ctl[j][2:0]) <= pi && !(j == i && i < 2 && m_ctl[i][6]))
                return 0;
        end
        return 1;
    endfunction

    function automatic int m_win();
        for (int p = 0; p < 8; p++)
            for (int i = 0; i < 4; i++)
                if (int'(m_ctl[i][2:0]) == p && m_elig(i)) return i;
        return -1;
    endfunction

    // Model step at each edge, then compare a quarter period later.
    always @(posedge clk) begin
        int w;
        bit take;
        w = m_win();
        take = inta && (w >= 0);
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_pv[i] = 0; m_pd[i] = 0; m_is[i] = 0;
                m_ctl[i] = 16'h000F;
            end
            m_cas[0] = 0; m_cas[1] = 0;
        end else begin
            for (int k = 0; k < 2; k++) m_cas[k] = take && (w == k) && m_ctl[k][5];
            for (int i = 0; i < 4; i++) begin
                if (m_ctl[i][4]) m_pd[i] = 0;
                else if (m_s2[i] && !m_pv[i]) m_pd[i] = 1;
                else if (take && w == i) m_pd[i] = 0;
                if (take && w == i) m_is[i] = 1;
                else if (we && addr == 3'd4 && int'(wdata[1:0]) == i) m_is[i] = 0;
                m_pv[i] = m_s2[i];
                m_s2[i] = m_s1[i];
                m_s1[i] = ext[i];
            end
            if (we && addr < 3'd4)
                m_ctl[addr] = wdata & ((addr < 3'd2) ? 16'h007F : 16'h001F);
        end
        started = 1;
        #(CLK_P/4);
        if (started) begin
            w = m_win();
            chk("R3 R4 R5 R8 R9 model irq", {31'd0, irq}, {31'd0, (w >= 0)});
            if (w >= 0) chk("R6 model type", {24'd0, itype}, 32'h0C + w);
            chk("R10 model strobe", {30'd0, cas}, {30'd0, m_cas[1], m_cas[0]});
            chk("R10 model enable", {30'd0, cas_en}, {30'd0, m_ctl[1][5], m_ctl[0][5]});
            chk("R2 model read", {16'd0, rdata}, (addr < 3'd4) ? {16'd0, m_ctl[addr]} : 32'd0);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic nwait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        we = 1; addr = a; wdata = d;
        @(negedge clk);
        we = 0; wdata = '0;
    endtask

    task automatic eoi(input int ch);
        wr(3'd4, 16'(ch));
    endtask

    task automatic pulse(input logic [3:0] m);
        ext = ext | m;
        @(negedge clk);
        ext = ext & ~m;
    endtask

    task automatic ack();
        inta = 1;
        @(negedge clk);
        inta = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
        addr = a;
        #1;
        chk(tag, {16'd0, rdata}, {16'd0, exp});
    endtask

    initial begin
        nwait(3);
        rst_n = 1;
        nwait(1);
        // R1: reset values
        for (int a = 0; a < 4; a++) rd(3'(a), 16'h000F, "R1 ctrl reset");
        chk("R1 irq reset", {31'd0, irq}, 32'd0);
        chk("R1 strobes reset", {28'd0, cas, cas_en}, 32'd0);
        // R2: reserved bits
        wr(3'd0, 16'hFFFF); rd(3'd0, 16'h007F, "R2 ch0 writable bits");
        wr(3'd2, 16'hFFFF); rd(3'd2, 16'h001F, "R2 ch2 writable bits");
        wr(3'd2, 16'h000F);
        wr(3'd0, 16'h0003);
        // R3: edge capture
        pulse(4'b0001);
        nwait(1);
        chk("R3 not yet", {31'd0, irq}, 32'd0);
        nwait(1);
        chk("R3 edge latched", {31'd0, irq}, 32'd1);
        chk("R6 type ch0", {24'd0, itype}, 32'h0C);
        ack();
        chk("R7 ack clears", {31'd0, irq}, 32'd0);
        eoi(0);
        chk("R7 pending gone", {31'd0, irq}, 32'd0);
        // R4: level capture
        wr(3'd1, 16'h0012);
        ext[1] = 1;
        nwait(3);
        chk("R4 level request", {31'd0, irq}, 32'd1);
        chk("R6 type ch1", {24'd0, itype}, 32'h0D);
        ext[1] = 0;
        nwait(3);
        chk("R4 level not latched", {31'd0, irq}, 32'd0);
        // R5: mask
        wr(3'd2, 16'h000A);
        pulse(4'b0100);
        nwait(4);
        chk("R5 masked", {31'd0, irq}, 32'd0);
        wr(3'd2, 16'h0002);
        chk("R5 unmasked held edge", {31'd0, irq}, 32'd1);
        chk("R5 type ch2", {24'd0, itype}, 32'h0E);
        ack(); eoi(2);
        // R6 and R8: ordering, ties, blocking
        wr(3'd0, 16'h0005); wr(3'd1, 16'h0005); wr(3'd3, 16'h0001);
        pulse(4'b1011);
        nwait(4);
        chk("R6 most urgent first", {24'd0, itype}, 32'h0F);
        ack();
        chk("R8 urgent service blocks", {31'd0, irq}, 32'd0);
        eoi(3);
        chk("R6 tie to lower index", {24'd0, itype}, 32'h0C);
        ack();
        chk("R8 equal blocked", {31'd0, irq}, 32'd0);
        eoi(0);
        chk("R8 released after eoi", {24'd0, itype}, 32'h0D);
        ack(); eoi(1);
        chk("R7 all served", {31'd0, irq}, 32'd0);
        wr(3'd0, 16'h0006); wr(3'd2, 16'h0001);
        pulse(4'b0001); nwait(4); ack();
        pulse(4'b0100); nwait(4);
        chk("R8 more urgent passes", {24'd0, itype}, 32'h0E);
        ack(); eoi(2); eoi(0);
        // R9: nested re-entry
        wr(3'd0, 16'h0044);
        pulse(4'b0001); nwait(4); ack();
        pulse(4'b0001); nwait(4);
        chk("R9 re-entry allowed", {31'd0, irq}, 32'd1);
        ack(); eoi(0);
        wr(3'd0, 16'h0004);
        pulse(4'b0001); nwait(4); ack();
        pulse(4'b0001); nwait(4);
        chk("R8 self blocked without nesting", {31'd0, irq}, 32'd0);
        eoi(0);
        chk("R8 self released", {31'd0, irq}, 32'd1);
        ack(); eoi(0);
        // R10: cascade
        wr(3'd1, 16'h0023);
        chk("R10 enable", {30'd0, cas_en}, 32'd2);
        wr(3'd3, 16'h0000);
        pulse(4'b1000); nwait(4);
        chk("R10 pin3 ignored", {31'd0, irq}, 32'd0);
        pulse(4'b0010); nwait(4);
        chk("R10 type ch1", {24'd0, itype}, 32'h0D);
        ack();
        chk("R10 strobe high", {30'd0, cas}, 32'd2);
        nwait(1);
        chk("R10 strobe one cycle", {30'd0, cas}, 32'd0);
        eoi(1);
        wr(3'd1, 16'h0003);
        chk("R10 pin3 released", {24'd0, itype}, 32'h0F);
        ack(); eoi(3);
        nwait(3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule